// File: doc/BRIEF.md
# Windowed RAM FIFO Read Controller

This block is the consumer-side controller of a FIFO whose entries live in a sub-range of a RAM shared with other FIFOs. The range is given at run time by a low and a high pointer bound, so its size need not be a power of two. The block owns the read pointer and compares it with the committed write pointer from its write-side partner. Words that were written but not yet committed are not visible to it. It issues reads to the RAM, collects each returned word in an output register, and hands that word to a consumer through a valid/ready handshake.

A grant input from an outside arbiter decides in which cycles the block may use the RAM port. The read pointer goes back to the write side every cycle, so that side can judge fullness. The block also reports how many committed entries are still in the RAM.

Top module: `ring_tail`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rd_ptr` equals `win_lo` and `out_valid` is 0.
- R2: Each read moves `rd_ptr` to `win_lo` if it was equal to `win_hi`, and otherwise to `rd_ptr + 1`. The pointer never changes in a cycle without a read.
- R3: No read is issued while `rd_ptr` equals `wr_cptr`. Entries the write side has written but not committed are never read.
- R4: While `grant` is low, `rd_en` stays low and `rd_ptr` does not move.
- R5: `rd_addr` is `rd_ptr`. The RAM returns the addressed word on `rd_data` one cycle after `rd_en` and holds it while `rd_en` is low. The block never has more than one word in flight plus one in its output register.
- R6: Once `out_valid` is high, it stays high and `out_data` stays stable until a cycle in which `out_ready` is high.
- R7: Words reach the consumer in commit order, with no loss and no duplication, under any pattern of back-pressure.
- R8: `occupancy` is `wr_cptr - rd_ptr` when that difference is not negative. Otherwise it is `(win_hi - win_lo + 1) - (rd_ptr - wr_cptr)`.
- R9: The window holds at most `win_hi - win_lo` entries. `occupancy` never exceeds that value and reaches it when the window is full.
- R10: With `grant` and `out_ready` held high, a burst of N committed words is delivered within N + 4 cycles of the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grant | input | 1 | RAM port granted this cycle |
| win_lo | input | AW | Lowest pointer of the window |
| win_hi | input | AW | Highest pointer of the window |
| wr_cptr | input | AW | Committed write pointer from the write side |
| rd_ptr | output | AW | Current read pointer, sent back to the write side |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | AW | RAM read address |
| rd_data | input | WIDTH | RAM read data, valid one cycle after `rd_en` |
| occupancy | output | UW | Committed entries still in the RAM |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | WIDTH | Output word |

## Verification
The hardest state to reach is a word sitting in the output register while a second word is in flight from the RAM and the consumer refuses both. The bench gets there by committing a burst while `out_ready` is held low. It then checks that the pointer has moved exactly two slots and that the first word is held. Next it releases the consumer in an irregular pattern to show that the in-flight word is not lost. Uncommitted visibility is tested by writing without a commit, then aborting and reusing the same slots with new data.

// File: rtl/ring_tail.sv
module ring_tail #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int UW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  input  logic [AW-1:0]    win_lo,
  input  logic [AW-1:0]    win_hi,
  input  logic [AW-1:0]    wr_cptr,
  output logic [AW-1:0]    rd_ptr,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] rd_data,
  output logic [UW-1:0]    occupancy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);

  logic [AW-1:0] ptr_q, ptr_nx;
  logic          pend_q;
  logic          empty, land;
  logic [AW:0]   diff;
  logic [UW-1:0] win_size;

  assign empty   = (ptr_q == wr_cptr);
  assign land    = pend_q & (~out_valid | out_ready);
  assign rd_en   = grant & ~empty & (~pend_q | land);
  assign ptr_nx  = (ptr_q == win_hi) ? win_lo : ptr_q + 1'b1;
  assign rd_ptr  = ptr_q;
  assign rd_addr = ptr_q;

  assign diff      = {1'b0, wr_cptr} - {1'b0, ptr_q};
  assign win_size  = UW'(win_hi) - UW'(win_lo) + UW'(1);
  assign occupancy = diff[AW] ? win_size - UW'(ptr_q - wr_cptr)
                              : UW'(diff[AW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= win_lo;
      pend_q    <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (rd_en) ptr_q <= ptr_nx;
      pend_q <= rd_en | (pend_q & ~land);
      if (land) begin
        out_valid <= 1'b1;
        out_data  <= rd_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ring_tail_chk.sv
module ring_tail_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int UW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             grant,
  input logic [AW-1:0]    win_lo,
  input logic [AW-1:0]    win_hi,
  input logic [AW-1:0]    wr_cptr,
  input logic [AW-1:0]    rd_ptr,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic [UW-1:0]    occupancy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data
);

  // R2
  wrap_to_low_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_addr == win_hi |=> rd_ptr == $past(win_lo));

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_addr != win_hi |=> rd_ptr == AW'($past(rd_ptr) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_ptr));

  // R3
  no_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rd_ptr != wr_cptr);

  // R4
  grant_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> grant);

  // R6
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9
  occ_limit_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy <= UW'(win_hi) - UW'(win_lo));

endmodule

bind ring_tail ring_tail_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/ring_tail_tb.sv
`timescale 1ns/1ps
module ring_tail_tb;
  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(DEPTH);
  localparam int UW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1, grant = 1'b0, out_ready = 1'b0;
  logic [AW-1:0]    win_lo = 4'd3, win_hi = 4'd9, wr_cptr = 4'd3;
  logic [AW-1:0]    rd_ptr, rd_addr;
  logic             rd_en, out_valid;
  logic [WIDTH-1:0] rd_data, out_data;
  logic [UW-1:0]    occupancy;

  ring_tail #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst(rst), .grant(grant), .win_lo(win_lo), .win_hi(win_hi),
    .wr_cptr(wr_cptr), .rd_ptr(rd_ptr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .occupancy(occupancy), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] ram_q = '0;
  always @(posedge clk) if (rd_en) ram_q <= mem[rd_addr];
  assign rd_data = ram_q;

  int checks = 0, fails = 0, accepts = 0;
  logic [WIDTH-1:0] expq[$];
  logic [WIDTH-1:0] stage[$];
  logic [AW-1:0] wp = 4'd3;
  logic [WIDTH-1:0] seq = 8'h40;
  logic prev_stall = 1'b0;
  logic [WIDTH-1:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == win_hi) ? win_lo : p + 1'b1;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) chk(out_valid && out_data == prev_data, "R6", int'(out_data), int'(prev_data));
      if (out_valid && out_ready) begin
        accepts++;
        if (expq.size() == 0) chk(1'b0, "R7", int'(out_data), -1);
        else begin
          logic [WIDTH-1:0] e;
          e = expq.pop_front();
          chk(out_data == e, "R7", int'(out_data), int'(e));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push();
    while (nxt(wp) == rd_ptr) tick();
    mem[wp] = seq;
    stage.push_back(seq);
    seq = seq + 8'd7;
    wp = nxt(wp);
    tick();
  endtask

  task automatic commit();
    wr_cptr = wp;
    foreach (stage[i]) expq.push_back(stage[i]);
    stage.delete();
    tick();
  endtask

  task automatic abort_writes();
    wp = wr_cptr;
    stage.delete();
  endtask

  task automatic drain();
    int n = 0;
    out_ready = 1'b1;
    grant = 1'b1;
    while ((expq.size() != 0 || out_valid) && n < 300) begin tick(); n++; end
    chk(expq.size() == 0, "R7", expq.size(), 0);
    chk(rd_ptr == wp, "R2", int'(rd_ptr), int'(wp));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rd_ptr == win_lo && !out_valid, "R1", int'(rd_ptr), int'(win_lo));
    rst = 1'b0;
    @(negedge clk);
    chk(rd_ptr == win_lo, "R1", int'(rd_ptr), int'(win_lo));
    chk(!out_valid, "R1", int'(out_valid), 0);
    chk(occupancy == 0, "R8", int'(occupancy), 0);
    tick();
  endtask

  task automatic t_stream();
    grant = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      push();
      if (i % 3 == 2) commit();
    end
    commit();
    drain();
  endtask

  task automatic t_uncommitted();
    logic [AW-1:0] rp0;
    grant = 1'b1; out_ready = 1'b1;
    rp0 = rd_ptr;
    for (int i = 0; i < 3; i++) push();
    repeat (8) tick();
    @(negedge clk);
    chk(!out_valid, "R3", int'(out_valid), 0);
    chk(rd_ptr == rp0, "R3", int'(rd_ptr), int'(rp0));
    chk(occupancy == 0, "R8", int'(occupancy), 0);
    tick();
    abort_writes();
    for (int i = 0; i < 2; i++) push();
    commit();
    drain();
  endtask

  task automatic t_grant();
    logic [AW-1:0] rp0;
    grant = 1'b0; out_ready = 1'b1;
    rp0 = rd_ptr;
    for (int i = 0; i < 3; i++) push();
    commit();
    repeat (6) tick();
    @(negedge clk);
    chk(!out_valid, "R4", int'(out_valid), 0);
    chk(rd_ptr == rp0, "R4", int'(rd_ptr), int'(rp0));
    tick();
    drain();
  endtask

  task automatic t_backpressure();
    logic [AW-1:0] rp0;
    grant = 1'b1; out_ready = 1'b0;
    rp0 = rd_ptr;
    for (int i = 0; i < 4; i++) push();
    commit();
    repeat (8) tick();
    @(negedge clk);
    chk(out_valid && out_data == expq[0], "R6", int'(out_data), int'(expq[0]));
    chk(rd_ptr == nxt(nxt(rp0)), "R5", int'(rd_ptr), int'(nxt(nxt(rp0))));
    tick();
    for (int i = 0; i < 30; i++) begin
      out_ready = (i % 3 != 0);
      if (i == 10) begin push(); push(); commit(); end
      else tick();
    end
    drain();
  endtask

  task automatic t_occupancy();
    for (int k = 1; k <= 6; k++) begin
      grant = 1'b0;
      for (int i = 0; i < k; i++) push();
      commit();
      @(negedge clk);
      chk(occupancy == UW'(k), "R8", int'(occupancy), k);
      if (k == 6) chk(occupancy == UW'(win_hi - win_lo), "R9", int'(occupancy), int'(win_hi - win_lo));
      tick();
      drain();
    end
  endtask

  task automatic t_rate();
    int a0, n;
    grant = 1'b1; out_ready = 1'b1;
    for (int i = 0; i < 6; i++) push();
    a0 = accepts;
    commit();
    n = 1;
    while (accepts < a0 + 6 && n < 50) begin tick(); n++; end
    chk(n <= 10, "R10", n, 10);
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_stream();
    t_uncommitted();
    t_grant();
    t_backpressure();
    t_occupancy();
    t_rate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule